// File: doc/BRIEF.md
# Maximum-Mode Bus Status Decoder

This block sits beside a processor running in maximum mode and turns its three encoded status lines into the discrete bus commands that memory and I/O devices need. No explicit cycle-start signal is provided. The decoder infers the start of a bus cycle when the status leaves the passive code. From that point it steps through the T-states itself: T1, T2, T3, any wait states, then T4. It produces the strobes on that schedule.

Outputs are an address latch pulse, active-low memory read/write, I/O read/write and interrupt acknowledge strobes, and a data enable with a transmit/receive direction for a data transceiver. During memory cycles, the decoder also decodes the two segment-status lines into one of four one-hot chip selects. A ready input, sampled at the end of T3 and of each wait state, decides whether the cycle moves on to T4 or inserts another wait.

Top module: `bus_status_decoder`

## Requirements
- R1: While rst_ni is low, and at once when it falls, every command strobe is high (inactive), ale_o, den_o and dt_tx_o are 0, and seg_cs_o is all zero.
- R2: A status change from 111 to any other value, seen at a clock edge while idle or in T4, starts a cycle. ale_o is then high for exactly the following clock (T1) and low otherwise.
- R3: Status codes map to strobes as follows: 000 gives inta_no, 001 gives io_rd_no, 010 gives io_wr_no, 100 and 101 give mem_rd_no, and 110 gives mem_wr_no. At most one strobe is low at any time.
- R4: Read and write strobes are low from T2 through T3 and any wait states, and high in T1 and T4.
- R5: inta_no is low in T2, T3, every wait state and T4 of an acknowledge cycle.
- R6: ready_i high at the clock edge ending T3 or a wait state moves the cycle to T4. ready_i low inserts one more wait state.
- R7: Status 011 (halt) produces no ale_o pulse, no strobe and no den_o.
- R8: den_o is 1 exactly while a command strobe is low. dt_tx_o is 1 from T1 through T4 of cycles with status 010 or 110, and 0 otherwise.
- R9: During T2 through T4 of a memory cycle (100, 101, 110), seg_cs_o has the single bit seg_i set: 00 sets bit 0 (extra), 01 sets bit 1 (stack), 10 sets bit 2 (code), 11 sets bit 3 (data). Otherwise seg_cs_o is zero.
- R10: A status that moves from one non-passive code to another, without passing through 111, does not start a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stat_i | input | 3 | Encoded bus status from the processor |
| seg_i | input | 2 | Segment status lines |
| ready_i | input | 1 | Transfer-complete acknowledge, sampled at the end of T3 and of each wait state |
| ale_o | output | 1 | Address latch enable, high in T1 |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| den_o | output | 1 | Data transceiver enable |
| dt_tx_o | output | 1 | Transceiver direction, 1 = transmit |
| seg_cs_o | output | 4 | One-hot segment chip selects |

## Verification
The assertions check these properties on every cycle:
- the address latch pulse lasts one clock and always follows a non-passive, non-halt status;
- no two strobes are ever low together;
- the latch pulse and the read/write strobes never overlap;
- a write strobe always comes with transmit direction;
- the chip selects are at most one-hot.

Only the bench scenarios can show the exact T-state on which each strobe rises and falls, and how ready_i stretches a cycle. The same holds for back-to-back cycles that start in T4, for the halt code, and for a non-passive-to-non-passive status change that must be ignored.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int STAT_W = 3;

  localparam logic [STAT_W-1:0] ST_INTA = 3'b000;
  localparam logic [STAT_W-1:0] ST_IORD = 3'b001;
  localparam logic [STAT_W-1:0] ST_IOWR = 3'b010;
  localparam logic [STAT_W-1:0] ST_HALT = 3'b011;
  localparam logic [STAT_W-1:0] ST_CODE = 3'b100;
  localparam logic [STAT_W-1:0] ST_MRD  = 3'b101;
  localparam logic [STAT_W-1:0] ST_MWR  = 3'b110;
  localparam logic [STAT_W-1:0] ST_PASS = 3'b111;

  typedef enum logic [2:0] {
    TS_IDLE, TS_T1, TS_T2, TS_T3, TS_TW, TS_T4
  } tstate_e;
endpackage

// File: rtl/bsd_cycle_fsm.sv
module bsd_cycle_fsm
  import bsd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              ready_i,
  output tstate_e           state_o,
  output logic [STAT_W-1:0] code_o,
  output logic              ale_o
);
  tstate_e           state_q, state_d;
  logic [STAT_W-1:0] code_q, code_d;
  logic              prev_pass_q;
  logic              start;

  // cycle begins only on a departure from passive, at a cycle boundary
  assign start = prev_pass_q && (stat_i != ST_PASS) &&
                 ((state_q == TS_IDLE) || (state_q == TS_T4));

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    unique case (state_q)
      TS_IDLE, TS_T4: begin
        if (start && (stat_i != ST_HALT)) begin
          state_d = TS_T1;
          code_d  = stat_i;
        end else begin
          state_d = TS_IDLE;
          code_d  = ST_PASS;
        end
      end
      TS_T1:        state_d = TS_T2;
      TS_T2:        state_d = TS_T3;
      TS_T3, TS_TW: state_d = ready_i ? TS_T4 : TS_TW;
      default:      state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= TS_IDLE;
      code_q      <= ST_PASS;
      prev_pass_q <= 1'b1;
    end else begin
      state_q     <= state_d;
      code_q      <= code_d;
      prev_pass_q <= (stat_i == ST_PASS);
    end
  end

  assign state_o = state_q;
  assign code_o  = code_q;
  assign ale_o   = (state_q == TS_T1);

  // R2
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  // R2
  ale_after_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ($past(stat_i) != ST_PASS));
  // R7
  ale_not_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ($past(stat_i) != ST_HALT));
endmodule

// File: rtl/bsd_cmd_gen.sv
module bsd_cmd_gen
  import bsd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  logic [STAT_W-1:0] code_i,
  input  logic              ale_i,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              inta_no,
  output logic              den_o,
  output logic              dt_tx_o,
  output logic              mem_cyc_o
);
  logic rw_win, ack_win, in_cycle;
  logic mrd, mwr, ird, iwr, ack;

  assign rw_win   = (state_i == TS_T2) || (state_i == TS_T3) || (state_i == TS_TW);
  assign ack_win  = rw_win || (state_i == TS_T4);
  assign in_cycle = (state_i != TS_IDLE);

  assign mrd = rw_win  && ((code_i == ST_CODE) || (code_i == ST_MRD));
  assign mwr = rw_win  && (code_i == ST_MWR);
  assign ird = rw_win  && (code_i == ST_IORD);
  assign iwr = rw_win  && (code_i == ST_IOWR);
  assign ack = ack_win && (code_i == ST_INTA);

  assign mem_rd_no = ~mrd;
  assign mem_wr_no = ~mwr;
  assign io_rd_no  = ~ird;
  assign io_wr_no  = ~iwr;
  assign inta_no   = ~ack;
  assign den_o     = mrd | mwr | ird | iwr | ack;
  assign dt_tx_o   = in_cycle && ((code_i == ST_IOWR) || (code_i == ST_MWR));
  assign mem_cyc_o = ack_win &&
                     ((code_i == ST_CODE) || (code_i == ST_MRD) || (code_i == ST_MWR));

  // R3
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~mem_rd_no, ~mem_wr_no, ~io_rd_no, ~io_wr_no, ~inta_no}));
  // R4
  no_ale_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |-> (mem_rd_no && mem_wr_no && io_rd_no && io_wr_no));
  // R8
  wr_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wr_no || !io_wr_no) |-> dt_tx_o);
endmodule

// File: rtl/bsd_seg_dec.sv
module bsd_seg_dec #(
  parameter int SEG_N = 4,
  localparam int SEG_W = $clog2(SEG_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mem_cyc_i,
  input  logic [SEG_W-1:0] seg_i,
  output logic [SEG_N-1:0] seg_cs_o
);
  for (genvar g = 0; g < SEG_N; g++) begin : g_cs
    assign seg_cs_o[g] = mem_cyc_i && (seg_i == SEG_W'(g));
  end

  // R9
  seg_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(seg_cs_o));
endmodule

// File: rtl/bus_status_decoder.sv
module bus_status_decoder
  import bsd_pkg::*;
#(
  parameter int SEG_N = 4,
  localparam int SEG_W = $clog2(SEG_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       stat_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic             ready_i,
  output logic             ale_o,
  output logic             mem_rd_no,
  output logic             mem_wr_no,
  output logic             io_rd_no,
  output logic             io_wr_no,
  output logic             inta_no,
  output logic             den_o,
  output logic             dt_tx_o,
  output logic [SEG_N-1:0] seg_cs_o
);
  tstate_e           state;
  logic [STAT_W-1:0] code;
  logic              mem_cyc;

  bsd_cycle_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stat_i  (stat_i),
    .ready_i (ready_i),
    .state_o (state),
    .code_o  (code),
    .ale_o   (ale_o)
  );

  bsd_cmd_gen u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .code_i    (code),
    .ale_i     (ale_o),
    .mem_rd_no (mem_rd_no),
    .mem_wr_no (mem_wr_no),
    .io_rd_no  (io_rd_no),
    .io_wr_no  (io_wr_no),
    .inta_no   (inta_no),
    .den_o     (den_o),
    .dt_tx_o   (dt_tx_o),
    .mem_cyc_o (mem_cyc)
  );

  bsd_seg_dec #(.SEG_N(SEG_N)) u_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mem_cyc_i (mem_cyc),
    .seg_i     (seg_i),
    .seg_cs_o  (seg_cs_o)
  );
endmodule

// File: tb/bus_status_decoder_tb.sv
module bus_status_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] stat = 3'b111;
  logic [1:0] seg = 2'b00;
  logic       ready = 1'b0;
  logic       ale, mrd_n, mwr_n, ird_n, iwr_n, inta_n, den, dt;
  logic [3:0] cs;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_status_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .stat_i(stat), .seg_i(seg), .ready_i(ready),
    .ale_o(ale), .mem_rd_no(mrd_n), .mem_wr_no(mwr_n), .io_rd_no(ird_n),
    .io_wr_no(iwr_n), .inta_no(inta_n), .den_o(den), .dt_tx_o(dt), .seg_cs_o(cs)
  );

  // {code, seg, waits, mask(mrd,mwr,ird,iwr,inta), dt, mem}
  localparam logic [13:0] VEC [6] = '{
    {3'b101, 2'b11, 2'd0, 5'b10000, 1'b0, 1'b1},
    {3'b110, 2'b01, 2'd1, 5'b01000, 1'b1, 1'b1},
    {3'b001, 2'b00, 2'd0, 5'b00100, 1'b0, 1'b0},
    {3'b010, 2'b10, 2'd2, 5'b00010, 1'b1, 1'b0},
    {3'b000, 2'b00, 2'd1, 5'b00001, 1'b0, 1'b0},
    {3'b100, 2'b10, 2'd0, 5'b10000, 1'b0, 1'b1}
  };

  function automatic logic [4:0] cmds();
    return {~mrd_n, ~mwr_n, ~ird_n, ~iwr_n, ~inta_n};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 strobes", {3'b0, cmds()}, 8'h00);
    chk("R1 ale/den/dt/cs", {1'b0, ale, den, dt, cs}, 8'h00);
    rst_ni = 1'b1;
    step();
    chk("R2 idle passive no ale", {7'b0, ale}, 8'h00);

    stat = VEC[0][13:11];
    seg  = VEC[0][10:9];
    for (int i = 0; i < 6; i++) begin
      logic [4:0] mask;
      int waits;
      mask  = VEC[i][6:2];
      waits = int'(VEC[i][8:7]);
      seg   = VEC[i][10:9];
      step();                                      // T1
      chk("R2 ale in T1", {7'b0, ale}, 8'h01);
      chk("R4 no strobe in T1", {3'b0, cmds()}, 8'h00);
      chk("R8 dt in T1", {7'b0, dt}, {7'b0, VEC[i][1]});
      step();                                      // T2
      chk("R3 strobe in T2", {3'b0, cmds()}, {3'b0, mask});
      chk("R2 ale low in T2", {7'b0, ale}, 8'h00);
      chk("R8 den/dt in T2", {6'b0, den, dt}, {6'b0, 1'b1, VEC[i][1]});
      chk("R9 seg cs", {4'b0, cs}, VEC[i][0] ? (8'h01 << seg) : 8'h00);
      stat = 3'b111;
      step();                                      // T3
      chk("R4 strobe in T3", {3'b0, cmds()}, {3'b0, mask});
      ready = (waits == 0);
      for (int k = 0; k < waits; k++) begin
        step();                                    // Tw
        chk("R6 wait keeps strobe", {3'b0, cmds()}, {3'b0, mask});
        chk("R6 wait den", {7'b0, den}, 8'h01);
        ready = (k == waits - 1);
      end
      step();                                      // T4
      chk("R4 R5 strobe in T4", {3'b0, cmds()}, {3'b0, mask & 5'b00001});
      chk("R8 dt in T4", {7'b0, dt}, {7'b0, VEC[i][1]});
      chk("R9 seg cs in T4", {4'b0, cs}, VEC[i][0] ? (8'h01 << seg) : 8'h00);
      ready = 1'b0;
      stat = (i < 5) ? VEC[i+1][13:11] : 3'b111;
    end
    step();
    chk("R2 idle after last cycle", {2'b0, ale, cmds()}, 8'h00);

    // R7 halt
    stat = 3'b011;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R7 halt quiet", {1'b0, ale, den, cmds()}, 8'h00);
    end
    // R10 non-passive to non-passive: no start
    stat = 3'b101;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10 no restart", {2'b0, ale, cmds()}, 8'h00);
    end
    stat = 3'b111;
    step();

    // R1 asynchronous reset in mid-cycle
    stat = 3'b110;
    seg  = 2'b11;
    step();
    stat = 3'b111;
    step();                                        // T2
    chk("R3 write strobe before reset", {3'b0, cmds()}, 8'h08);
    #1 rst_ni = 1'b0;
    #1 chk("R1 async clear", {ale, den, dt, cmds()}, 8'h00);
    chk("R1 async cs", {4'b0, cs}, 8'h00);
    step();
    rst_ni = 1'b1;
    step();
    chk("R1 idle after reset", {2'b0, ale, cmds()}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule